// File: doc/BRIEF.md
# Control-Flow Microcode Sequencer

This block steps a small CPU through the jump, call, return and stack-page instructions that move across a 24-bit address space. A 4-bit step counter runs through a fixed sequence for each instruction. Each step drives one control word onto the datapath. A control word carries a bus-source select code with its enable, PC increment and load, SP increment and decrement, low and high address register loads, a memory write strobe and the instruction-register load. The datapath and every other instruction sit outside this block.

Every instruction starts with the same two fetch steps. After that, the opcode held in the instruction register selects the steps that follow. Long-form instructions read their high address word into a second instruction word register. A long call saves the PC and the high address byte as two separate stack entries, and a long return restores them the same way. Each instruction has its own length, and the counter returns to step 0 after that instruction's final step.

Top module: `uc_flow_seq`

## Requirements
- R1: While reset is held, and in the one idle step (counter value 15) after reset, the control word is all zeros. The first step after reset is fetch step 0.
- R2: Fetch step 0 enables the bus with select 00000 (PC) and loads the low address register. Fetch step 1 selects 11111 (memory out), loads the instruction register and increments the PC. These two steps run before every instruction.
- R3: Opcode 0x209 (long jump) takes 7 cycles. The PC is loaded from the third instruction word, and the high address byte is loaded from the low 8 bits of the second word.
- R4: Opcode 0x205 (long call) takes 11 cycles. It writes the PC, which points at the first operand word, to the stack address. It then writes the high address byte one stack entry lower. SP decrements once after each write. The PC and high byte are then loaded as in R3.
- R5: Opcode 0x207 (long return) takes 9 cycles. It increments SP and reads the high byte into the second word register. It increments SP again and reads the PC. It then restores the high byte and increments the PC twice.
- R6: Opcode 0x206 (page call) takes 6 cycles. It pushes the PC, decrements SP, and loads the PC from the operand word. The high address byte is unchanged.
- R7: Opcode 0x208 (page return) takes 6 cycles. It increments SP, loads the PC from the stack, and then increments the PC once.
- R8: Opcode 0x20A (stack-page load) takes 4 cycles. Step 2 puts the PC on the low address. Step 3 uses select 11011, which loads the stack page from memory, and increments the PC.
- R9: Any other opcode takes 3 cycles. Its step 2 has an all-zero control word, and the counter then returns to fetch.
- R10: The select codes are: 00001 SP, 11000 memory into the second word register, 11001 second word out, 11010 high address byte out. When SP drives a low address load, the memory access uses the stack page as its high byte. A memory write always has the bus enabled. PC increment and load never occur together. SP increment and decrement never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 16 | Instruction register value |
| ctl_oe_en | output | 1 | Bus source enable |
| ctl_oe_sel | output | 5 | Bus source select code |
| ctl_pc_inc | output | 1 | PC increment |
| ctl_pc_load | output | 1 | PC load from bus |
| ctl_sp_inc | output | 1 | SP increment |
| ctl_sp_dec | output | 1 | SP decrement |
| ctl_lo_ld | output | 1 | Low address register load |
| ctl_hi_ld | output | 1 | High address byte load |
| ctl_mem_wr | output | 1 | Memory write |
| ctl_ir_ld | output | 1 | Instruction register load |

## Verification
The long call and long return must operate on exactly the same two stack entries. A mismatch only shows up after a round trip, so the stack-page load has to run first to move the stack into a separate page. After that, a long call and a long return run back to back, and the restored PC and high byte are compared. A behavioural datapath driven only by the control word runs a short program that exercises every opcode, including an unknown one. The length of each instruction is measured as the number of cycles between successive instruction-register loads.

// File: rtl/uc_flow_seq.sv
module uc_flow_seq #(
  parameter int IW = 16,
  parameter int SW = 4,
  parameter int SELW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   instr,
  output logic            ctl_oe_en,
  output logic [SELW-1:0] ctl_oe_sel,
  output logic            ctl_pc_inc,
  output logic            ctl_pc_load,
  output logic            ctl_sp_inc,
  output logic            ctl_sp_dec,
  output logic            ctl_lo_ld,
  output logic            ctl_hi_ld,
  output logic            ctl_mem_wr,
  output logic            ctl_ir_ld
);
  localparam int NF = 8;
  localparam int CW = 1 + SELW + NF;
  localparam logic [SW-1:0] STEP_IDLE = '1;

  localparam logic [IW-1:0] OP_CALL_L = IW'('h205);
  localparam logic [IW-1:0] OP_CALL_P = IW'('h206);
  localparam logic [IW-1:0] OP_RET_L  = IW'('h207);
  localparam logic [IW-1:0] OP_RET_P  = IW'('h208);
  localparam logic [IW-1:0] OP_JMP_L  = IW'('h209);
  localparam logic [IW-1:0] OP_SPAGE  = IW'('h20A);

  localparam logic [SELW-1:0] S_PC   = SELW'(5'b00000);
  localparam logic [SELW-1:0] S_SP   = SELW'(5'b00001);
  localparam logic [SELW-1:0] S_W2IN = SELW'(5'b11000);
  localparam logic [SELW-1:0] S_W2OT = SELW'(5'b11001);
  localparam logic [SELW-1:0] S_HIOT = SELW'(5'b11010);
  localparam logic [SELW-1:0] S_SPG  = SELW'(5'b11011);
  localparam logic [SELW-1:0] S_MEM  = SELW'(5'b11111);

  localparam logic [NF-1:0] F_PCI = 8'h80;
  localparam logic [NF-1:0] F_PCL = 8'h40;
  localparam logic [NF-1:0] F_SPI = 8'h20;
  localparam logic [NF-1:0] F_SPD = 8'h10;
  localparam logic [NF-1:0] F_LO  = 8'h08;
  localparam logic [NF-1:0] F_HI  = 8'h04;
  localparam logic [NF-1:0] F_WR  = 8'h02;
  localparam logic [NF-1:0] F_IR  = 8'h01;

  function automatic logic [CW-1:0] drv(input logic [SELW-1:0] s, input logic [NF-1:0] f);
    return {1'b1, s, f};
  endfunction

  function automatic logic [CW-1:0] quiet(input logic [NF-1:0] f);
    return {1'b0, {SELW{1'b0}}, f};
  endfunction

  logic [SW-1:0] step_q;
  logic [CW-1:0] word;
  logic          last;

  always_comb begin
    word = '0;
    last = 1'b0;
    if (step_q == STEP_IDLE) begin
      last = 1'b1;
    end else if (step_q == SW'(0)) begin
      word = drv(S_PC, F_LO);
    end else if (step_q == SW'(1)) begin
      word = drv(S_MEM, F_IR | F_PCI);
    end else begin
      case (instr)
        OP_JMP_L: begin
          case (step_q)
            SW'(2): word = drv(S_PC, F_LO);
            SW'(3): word = drv(S_W2IN, F_PCI);
            SW'(4): word = drv(S_PC, F_LO);
            SW'(5): word = drv(S_MEM, F_PCL);
            SW'(6): begin word = drv(S_W2OT, F_HI); last = 1'b1; end
            default: last = 1'b1;
          endcase
        end
        OP_CALL_L: begin
          case (step_q)
            SW'(2):  word = drv(S_SP, F_LO);
            SW'(3):  word = drv(S_PC, F_WR | F_SPD);
            SW'(4):  word = drv(S_SP, F_LO);
            SW'(5):  word = drv(S_HIOT, F_WR | F_SPD);
            SW'(6):  word = drv(S_PC, F_LO);
            SW'(7):  word = drv(S_W2IN, F_PCI);
            SW'(8):  word = drv(S_PC, F_LO);
            SW'(9):  word = drv(S_MEM, F_PCL);
            SW'(10): begin word = drv(S_W2OT, F_HI); last = 1'b1; end
            default: last = 1'b1;
          endcase
        end
        OP_RET_L: begin
          case (step_q)
            SW'(2): word = quiet(F_SPI);
            SW'(3): word = drv(S_SP, F_LO);
            SW'(4): word = drv(S_W2IN, F_SPI);
            SW'(5): word = drv(S_SP, F_LO);
            SW'(6): word = drv(S_MEM, F_PCL);
            SW'(7): word = drv(S_W2OT, F_HI | F_PCI);
            SW'(8): begin word = quiet(F_PCI); last = 1'b1; end
            default: last = 1'b1;
          endcase
        end
        OP_CALL_P: begin
          case (step_q)
            SW'(2): word = drv(S_SP, F_LO);
            SW'(3): word = drv(S_PC, F_WR | F_SPD);
            SW'(4): word = drv(S_PC, F_LO);
            SW'(5): begin word = drv(S_MEM, F_PCL); last = 1'b1; end
            default: last = 1'b1;
          endcase
        end
        OP_RET_P: begin
          case (step_q)
            SW'(2): word = quiet(F_SPI);
            SW'(3): word = drv(S_SP, F_LO);
            SW'(4): word = drv(S_MEM, F_PCL);
            SW'(5): begin word = quiet(F_PCI); last = 1'b1; end
            default: last = 1'b1;
          endcase
        end
        OP_SPAGE: begin
          case (step_q)
            SW'(2): word = drv(S_PC, F_LO);
            SW'(3): begin word = drv(S_SPG, F_PCI); last = 1'b1; end
            default: last = 1'b1;
          endcase
        end
        default: last = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step_q <= STEP_IDLE;
    else if (last) step_q <= '0;
    else step_q <= step_q + 1'b1;
  end

  assign ctl_oe_en   = word[CW-1];
  assign ctl_oe_sel  = word[CW-2 -: SELW];
  assign ctl_pc_inc  = word[7];
  assign ctl_pc_load = word[6];
  assign ctl_sp_inc  = word[5];
  assign ctl_sp_dec  = word[4];
  assign ctl_lo_ld   = word[3];
  assign ctl_hi_ld   = word[2];
  assign ctl_mem_wr  = word[1];
  assign ctl_ir_ld   = word[0];

  a_r1_idle_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == STEP_IDLE) |=> (ctl_oe_en && ctl_oe_sel == S_PC && ctl_lo_ld));
  a_r2_fetch_loads_ir: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == SW'(0)) |=> ctl_ir_ld);
  a_r2_ir_single: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ir_ld |=> !ctl_ir_ld);
  a_r10_pc_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_pc_inc && ctl_pc_load));
  a_r10_sp_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_sp_inc && ctl_sp_dec));
  a_r10_wr_driven: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_mem_wr |-> ctl_oe_en);
  a_r4_push_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_mem_wr |-> ctl_sp_dec);
  a_r9_unknown_short: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == SW'(2) && !ctl_oe_en && !ctl_sp_inc) |=> (step_q == SW'(0)));
endmodule

// File: tb/uc_flow_seq_tb_top.sv
module uc_flow_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] ir;
  logic oe_en, pc_inc, pc_ld, sp_inc, sp_dec, lo_ld, hi_ld, wr, ir_ld;
  logic [4:0] sel;

  always #4 clk = ~clk;

  uc_flow_seq dut_i (
    .clk(clk), .rst_n(rst_n), .instr(ir),
    .ctl_oe_en(oe_en), .ctl_oe_sel(sel), .ctl_pc_inc(pc_inc), .ctl_pc_load(pc_ld),
    .ctl_sp_inc(sp_inc), .ctl_sp_dec(sp_dec), .ctl_lo_ld(lo_ld), .ctl_hi_ld(hi_ld),
    .ctl_mem_wr(wr), .ctl_ir_ld(ir_ld)
  );

  logic [15:0] mem [logic [23:0]];
  logic [15:0] pc, sp, lo, w2;
  logic [7:0]  hi, spage;
  logic        use_stk;
  int          cnt, fetch_cnt, snap_len;
  logic [15:0] snap_pc, snap_sp;
  logic [7:0]  snap_hi;
  int          n_chk = 0;
  int          n_fail = 0;

  function automatic logic [15:0] rd(input logic [23:0] a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  always @(posedge clk) begin : model
    logic [15:0] b;
    logic [23:0] ma;
    ma = {use_stk ? spage : hi, lo};
    if (!rst_n) begin
      pc <= '0; sp <= 16'hFFFF; lo <= '0; w2 <= '0; hi <= '0; spage <= 8'hFF;
      use_stk <= 1'b0; ir <= '0; cnt <= 0; fetch_cnt <= 0; snap_len <= 0;
      snap_pc <= '0; snap_sp <= '0; snap_hi <= '0;
    end else begin
      b = 16'h0;
      if (oe_en) begin
        case (sel)
          5'b00000: b = pc;
          5'b00001: b = sp;
          5'b11000, 5'b11011, 5'b11111: b = rd(ma);
          5'b11001: b = w2;
          5'b11010: b = {8'h00, hi};
          default: b = 16'h0;
        endcase
      end
      if (lo_ld) begin lo <= b; use_stk <= oe_en && sel == 5'b00001; end
      if (hi_ld) hi <= b[7:0];
      if (pc_ld) pc <= b; else if (pc_inc) pc <= pc + 16'd1;
      if (sp_inc) sp <= sp + 16'd1; else if (sp_dec) sp <= sp - 16'd1;
      if (wr) mem[ma] = b;
      if (oe_en && sel == 5'b11000) w2 <= b;
      if (oe_en && sel == 5'b11011) spage <= b[7:0];
      if (ir_ld) begin
        ir <= b; snap_len <= cnt; cnt <= 1; fetch_cnt <= fetch_cnt + 1;
        snap_pc <= pc; snap_hi <= hi; snap_sp <= sp;
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_next(input int target);
    for (int i = 0; i < 40 && fetch_cnt != target; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 control word in reset", {oe_en, sel, pc_inc, pc_ld, sp_inc, sp_dec, lo_ld, hi_ld, wr, ir_ld}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_fetch();
    chk("R1/R2 first step is fetch 0", {oe_en, sel, pc_inc, pc_ld, sp_inc, sp_dec, lo_ld, hi_ld, wr, ir_ld}, {1'b1, 5'b00000, 8'h08});
    @(negedge clk);
    chk("R2 fetch step 1", {oe_en, sel, pc_inc, pc_ld, sp_inc, sp_dec, lo_ld, hi_ld, wr, ir_ld}, {1'b1, 5'b11111, 8'h81});
  endtask

  task automatic t_stack_page();
    wait_next(2);
    chk("R8 length", snap_len, 4);
    chk("R8 stack page", spage, 8'hCF);
    chk("R8 pc", snap_pc, 16'h0002);
  endtask

  task automatic t_call_long();
    wait_next(3);
    chk("R4 length", snap_len, 11);
    chk("R4 pc", snap_pc, 16'h0300);
    chk("R4 high byte", snap_hi, 8'h05);
    chk("R4 sp", snap_sp, 16'hFFFD);
    chk("R4 saved pc", rd(24'hCFFFFF), 16'h0003);
    chk("R4 saved high byte", rd(24'hCFFFFE), 16'h0000);
  endtask

  task automatic t_ret_long();
    wait_next(4);
    chk("R5 length", snap_len, 9);
    chk("R5 pc", snap_pc, 16'h0005);
    chk("R5 high byte", snap_hi, 8'h00);
    chk("R5 sp", snap_sp, 16'hFFFF);
  endtask

  task automatic t_call_page();
    wait_next(5);
    chk("R6 length", snap_len, 6);
    chk("R6 pc", snap_pc, 16'h0040);
    chk("R6 high byte kept", snap_hi, 8'h00);
    chk("R6 sp", snap_sp, 16'hFFFE);
    chk("R6 saved pc", rd(24'hCFFFFF), 16'h0006);
  endtask

  task automatic t_ret_page();
    wait_next(6);
    chk("R7 length", snap_len, 6);
    chk("R7 pc", snap_pc, 16'h0007);
    chk("R7 sp", snap_sp, 16'hFFFF);
  endtask

  task automatic t_jump_long();
    wait_next(7);
    chk("R3 length", snap_len, 7);
    chk("R3 pc", snap_pc, 16'h0200);
    chk("R3 high byte", snap_hi, 8'h07);
  endtask

  task automatic t_unknown();
    wait_next(8);
    chk("R9 length", snap_len, 3);
    chk("R9 pc", snap_pc, 16'h0201);
    chk("R9 high byte", snap_hi, 8'h07);
    chk("R9 sp", snap_sp, 16'hFFFF);
  endtask

  initial begin
    mem[24'h000000] = 16'h020A; mem[24'h000001] = 16'h00CF;
    mem[24'h000002] = 16'h0205; mem[24'h000003] = 16'h0005; mem[24'h000004] = 16'h0300;
    mem[24'h050300] = 16'h0207;
    mem[24'h000005] = 16'h0206; mem[24'h000006] = 16'h0040;
    mem[24'h000040] = 16'h0208;
    mem[24'h000007] = 16'h0209; mem[24'h000008] = 16'h0007; mem[24'h000009] = 16'h0200;
    mem[24'h070200] = 16'h01FF;
    mem[24'h070201] = 16'h0209; mem[24'h070202] = 16'h0000; mem[24'h070203] = 16'h0000;
    repeat (3) @(negedge clk);
    t_reset();
    t_fetch();
    t_stack_page();
    t_call_long();
    t_ret_long();
    t_call_page();
    t_ret_page();
    t_jump_long();
    t_unknown();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule